// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles. It uses restoring long division and produces one quotient bit per cycle. A mode input selects unsigned or two's-complement operation. In signed mode the block divides the magnitudes of the operands and corrects the signs of both results in one final cycle.

The remainder is written to a high result register and the quotient to a low result register. Both registers keep their value until the next division completes.

The caller pulses `start` with the operands while the block is idle. It then waits for the one-cycle `done` pulse and reads the results. A zero divisor does not trap. It sets a status flag, and the results take a fixed, documented pattern.

Top module: `seq_divider`

## Requirements
- R1: A `start` sampled while `busy` is 0 makes `busy` 1 from the next cycle. `busy` stays 1 for exactly WIDTH+1 cycles (32 division steps plus one sign-fix cycle). As `busy` falls, `done` is 1 for exactly one cycle.
- R2: A `start` sampled while `busy` is 1 is ignored. The running division finishes on its original operands, and no extra division follows.
- R3: With `isSigned`=0, the operands are unsigned. `loOut` gets the quotient `floor(a/b)` and `hiOut` gets `a mod b`.
- R4: With `isSigned`=1, the operands are two's complement. The quotient is truncated toward zero, and it is negative exactly when the operand signs differ and the quotient is nonzero.
- R5: In signed mode the remainder has the sign of the dividend, its magnitude is below that of the divisor, and quotient*divisor+remainder equals the dividend.
- R6: A zero divisor sets `divByZero`=1 at completion and gives `loOut` = all ones and `hiOut` = the dividend, in either mode. A nonzero divisor gives `divByZero`=0.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000, remainder 0 and `divByZero`=0.
- R8: After reset, `busy`, `done` and `divByZero` are 0, and `hiOut` and `loOut` are 0.
- R9: `hiOut`, `loOut` and `divByZero` change only at the edge that raises `done`. They hold their values while idle, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division with the current operands (used only when idle) |
| isSigned | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when new results are in the result registers |
| divByZero | output | 1 | Last completed division had a zero divisor |
| hiOut | output | 32 | Remainder register |
| loOut | output | 32 | Quotient register |

## Verification
The bench covers every sign combination, because a design that skips the final sign correction returns positive results for negative inputs. It also runs the most negative dividend over -1: a design that reads the magnitude 0x80000000 as signed either flags an error or produces a wrong remainder. Zero divisors are run in both modes: a design that applies sign correction to the forced quotient returns 1 instead of all ones. A restart pulse is issued in the middle of a run, and the bench counts the edges from `start` to `done`. Together these expose a controller that restarts on a second `start`, or that is off by one in its step count and drops or repeats a quotient bit.

// File: rtl/div_pkg.sv
package div_pkg;

  // Strobes from the controller to the datapath; at most one is set per cycle.
  typedef struct packed {
    logic load;   // capture operand magnitudes and sign intents
    logic step;   // one restoring-division iteration
    logic fixup;  // apply signs, write result registers
  } divStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output divStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  divState_t        state;
  divState_t        stateNext;
  logic [CNT_W-1:0] stepCnt;
  logic             doneReg;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strb.fixup = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= strb.fixup;
      if (strb.load)      stepCnt <= '0;
      else if (strb.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strb,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut,
  output logic             divByZero
);

  localparam int SH_W = WIDTH + 1;  // shifted partial remainder
  localparam int TR_W = WIDTH + 2;  // trial difference with borrow bit

  logic [WIDTH-1:0] remReg;
  logic [WIDTH-1:0] quoReg;
  logic [WIDTH-1:0] divReg;
  logic             negQuo;
  logic             negRem;
  logic             zeroDiv;
  logic [WIDTH-1:0] hiReg;
  logic [WIDTH-1:0] loReg;
  logic             dbzReg;

  // Operand magnitudes; the most negative value keeps its bit pattern,
  // which is its correct unsigned magnitude.
  logic             aNeg;
  logic             bNeg;
  logic [WIDTH-1:0] absA;
  logic [WIDTH-1:0] absB;

  assign aNeg = isSigned & dividend[WIDTH-1];
  assign bNeg = isSigned & divisor[WIDTH-1];
  assign absA = aNeg ? (~dividend + 1'b1) : dividend;
  assign absB = bNeg ? (~divisor + 1'b1) : divisor;

  // One restoring iteration: shift in the next dividend bit, try the subtract,
  // and restore (keep the shifted value) when the trial goes negative.
  logic [SH_W-1:0] shifted;
  logic [TR_W-1:0] trial;
  logic            trialNeg;
  logic [WIDTH-1:0] remNext;

  assign shifted  = {remReg, quoReg[WIDTH-1]};
  assign trial    = {1'b0, shifted} - {2'b00, divReg};
  assign trialNeg = trial[TR_W-1];
  assign remNext  = trialNeg ? shifted[WIDTH-1:0] : trial[WIDTH-1:0];

  logic [WIDTH-1:0] quoSigned;
  logic [WIDTH-1:0] remSigned;

  assign quoSigned = negQuo ? (~quoReg + 1'b1) : quoReg;
  assign remSigned = negRem ? (~remReg + 1'b1) : remReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      divReg  <= '0;
      negQuo  <= 1'b0;
      negRem  <= 1'b0;
      zeroDiv <= 1'b0;
      hiReg   <= '0;
      loReg   <= '0;
      dbzReg  <= 1'b0;
    end else begin
      if (strb.load) begin
        remReg  <= '0;
        quoReg  <= absA;
        divReg  <= absB;
        negQuo  <= aNeg ^ bNeg;
        negRem  <= aNeg;
        zeroDiv <= (divisor == '0);
      end
      if (strb.step) begin
        remReg <= remNext;
        quoReg <= {quoReg[WIDTH-2:0], ~trialNeg};
      end
      if (strb.fixup) begin
        hiReg  <= remSigned;
        loReg  <= zeroDiv ? '1 : quoSigned;
        dbzReg <= zeroDiv;
      end
    end
  end

  assign hiOut     = hiReg;
  assign loOut     = loReg;
  assign divByZero = dbzReg;

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divByZero,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  divStrobe_t strb;

  div_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  div_datapath #(.WIDTH(WIDTH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .isSigned  (isSigned),
    .dividend  (dividend),
    .divisor   (divisor),
    .hiOut     (hiOut),
    .loOut     (loOut),
    .divByZero (divByZero)
  );

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             divByZero,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);

  localparam int BC_W = $clog2(WIDTH + 2) + 1;

  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R1: an accepted start raises busy on the next cycle
  a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R1: done is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: done arrives as busy falls, after WIDTH+1 busy cycles
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && busyCnt == BC_W'(WIDTH + 1)));

  // R2: a second start cannot stretch a run past its length
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt <= BC_W'(WIDTH)));

  // R6: a zero divisor forces an all-ones quotient
  a_r6_dbz_quotient: assert property (@(posedge clk) disable iff (!rstN)
    (done && divByZero) |-> (loOut == '1));

  // R9: results move only on the completing edge
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hiOut) && $stable(loOut) && $stable(divByZero)));

endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .divByZero (divByZero),
  .hiOut     (hiOut),
  .loOut     (loOut)
);

// File: tb/tb_seq_divider.sv
module tb_seq_divider;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         isSigned = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] hiOut, loOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  seq_divider #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .divByZero(divByZero), .hiOut(hiOut), .loOut(loOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference results computed from the requirements with plain integer ops.
  function automatic void refDiv(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic sg, output logic [W-1:0] q,
                                 output logic [W-1:0] r, output logic z);
    z = (b == '0);
    if (z) begin
      q = '1; r = a;
    end else if (!sg) begin
      q = a / b; r = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000; r = '0;
    end else begin
      q = $signed(a) / $signed(b);
      r = $signed(a) % $signed(b);
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Cycle model: busy/done/results per clock, fed only by the ports.
  logic         mBusy, mDone, mDbz;
  logic [W-1:0] mHi, mLo, mA, mB;
  logic         mSg;
  int           mCount;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mDbz <= 0; mHi <= '0; mLo <= '0;
      mCount <= 0; mA <= '0; mB <= '0; mSg <= 0;
    end else begin
      mDone <= 0;
      if (!mBusy) begin
        if (start) begin
          mBusy <= 1; mCount <= 0; mA <= dividend; mB <= divisor; mSg <= isSigned;
        end
      end else if (mCount == W) begin
        logic [W-1:0] q, r;
        logic z;
        refDiv(mA, mB, mSg, q, r, z);
        mBusy <= 0; mDone <= 1; mHi <= r; mLo <= q; mDbz <= z;
      end else begin
        mCount <= mCount + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1", "busy", {31'b0, busy}, {31'b0, mBusy});
      check("R1", "done", {31'b0, done}, {31'b0, mDone});
      check("R9", "hiOut", hiOut, mHi);
      check("R9", "loOut", loOut, mLo);
      check("R6", "divByZero", {31'b0, divByZero}, {31'b0, mDbz});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulseStart(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg);
    @(negedge clk);
    dividend = a; divisor = b; isSigned = sg; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Returns negedges from the start negedge to the negedge that sees done.
  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg,
                       input string tag);
    logic [W-1:0] q, r;
    logic z;
    int lat;
    refDiv(a, b, sg, q, r, z);
    pulseStart(a, b, sg);
    waitDone(lat);
    check(tag, "quotient loOut", loOut, q);
    check(tag, "remainder hiOut", hiOut, r);
    check(tag, "divByZero", {31'b0, divByZero}, {31'b0, z});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8: reset state
    check("R8", "busy", {31'b0, busy}, '0);
    check("R8", "done", {31'b0, done}, '0);
    check("R8", "divByZero", {31'b0, divByZero}, '0);
    check("R8", "hiOut", hiOut, '0);
    check("R8", "loOut", loOut, '0);

    // R1: latency from start to done
    begin
      int lat;
      pulseStart(32'd100, 32'd7, 0);
      waitDone(lat);
      check("R1", "start-to-done negedges", lat, W + 2);
      check("R3", "100/7 quotient", loOut, 32'd14);
      check("R3", "100 mod 7", hiOut, 32'd2);
    end

    // R3: unsigned patterns
    runOp(32'hFFFF_FFFF, 32'd1, 0, "R3");
    runOp(32'd5, 32'd9, 0, "R3");
    runOp(32'hFFFF_FFFF, 32'h0001_0000, 0, "R3");
    runOp(32'h8000_0000, 32'hFFFF_FFFF, 0, "R3");
    runOp(32'hDEAD_BEEF, 32'h0000_1234, 0, "R3");

    // R4 / R5: signed sign combinations
    runOp(-32'sd7, 32'sd2, 1, "R4");
    check("R5", "-7 rem 2", hiOut, 32'hFFFF_FFFF);
    runOp(32'sd7, -32'sd2, 1, "R4");
    check("R5", "7 rem -2", hiOut, 32'd1);
    runOp(-32'sd7, -32'sd2, 1, "R4");
    check("R4", "-7/-2 quotient", loOut, 32'd3);
    runOp(-32'sd100000, 32'sd37, 1, "R5");
    runOp(32'sd3, -32'sd5, 1, "R4");
    check("R4", "3/-5 quotient zero", loOut, 32'd0);

    // R7: most negative over -1
    runOp(32'h8000_0000, 32'hFFFF_FFFF, 1, "R7");
    check("R7", "min/-1 quotient", loOut, 32'h8000_0000);
    check("R7", "min/-1 remainder", hiOut, 32'd0);

    // R6: zero divisor, both modes
    runOp(32'd1234, 32'd0, 0, "R6");
    check("R6", "quotient all ones", loOut, 32'hFFFF_FFFF);
    runOp(-32'sd5, 32'd0, 1, "R6");
    check("R6", "remainder is dividend", hiOut, 32'hFFFF_FFFB);
    check("R6", "flag set", {31'b0, divByZero}, 32'd1);
    runOp(32'd9, 32'd3, 1, "R6");
    check("R6", "flag clear", {31'b0, divByZero}, 32'd0);

    // R2: start while busy is ignored
    begin
      int lat;
      pulseStart(32'd1000, 32'd10, 0);
      repeat (5) @(negedge clk);
      dividend = 32'd77; divisor = 32'd0; start = 1;
      @(negedge clk);
      start = 0;
      waitDone(lat);
      check("R2", "quotient of first operands", loOut, 32'd100);
      check("R2", "remainder of first operands", hiOut, 32'd0);
      check("R2", "no zero-divisor flag", {31'b0, divByZero}, 32'd0);
      repeat (3) @(negedge clk);
      check("R2", "no second run", {31'b0, busy}, 32'd0);
    end

    // R9: hold while idle with changing inputs
    dividend = 32'h1234_5678; divisor = 32'd0; isSigned = 1;
    repeat (10) @(negedge clk);
    check("R9", "hiOut held", hiOut, 32'd0);
    check("R9", "loOut held", loOut, 32'd100);
    check("R9", "divByZero held", {31'b0, divByZero}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule